// File: doc/BRIEF.md
# Bit-Serial CRC-8 Check Unit for a Single-Wire Bus

This unit computes the eight-bit cyclic check used on a single-wire sensor bus. The generator polynomial is x^8 + x^5 + x^4 + 1. Data enters one bit per step, least significant bit first, into a register that starts from zero. The same unit serves two purposes. It can verify a 64-bit device identity: 56 data bits go in, and the register then holds the byte that belongs in the identity's top byte. It can also produce the check byte that is sent after an eight-byte scratchpad readout.

Bits can arrive in two ways. A serial port takes one data bit per strobe. A byte port takes a whole byte in one cycle and feeds its bits to the generator over eight consecutive cycles, lowest bit first. A zero flag is high whenever the register is zero. A receiver can therefore shift the data and the received check byte through the unit and test the flag afterwards. The surrounding logic chooses which bytes are covered and when the register is cleared.

Top module: `owcrc_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `crc_o` is 8'h00, `crc_zero_o` is 1 and `byte_busy_o` is 0.
- R2: One step with data bit d works as follows. Compute f = d XOR crc[0]. Shift the register right by one. If f is 1, XOR the result with 8'h8C, which toggles bits 7, 3 and 2. The new value appears on `crc_o` after the clock edge of the step.
- R3: `clr_i` loads 8'h00. If a step happens in the same cycle, that step is applied to the zero seed. For example, clear together with data bit 1 gives 8'h8C, and clear together with data bit 0 gives 8'h00.
- R4: In a cycle with no clear and no step, `crc_o` keeps its value.
- R5: A byte on `byte_i` with `byte_vld_i` high is accepted when `byte_busy_o` is low. Bit 0 is stepped in the accepting cycle, and bits 1 to 7 are stepped in the next seven cycles. `byte_busy_o` is high for exactly those seven cycles.
- R6: While `byte_busy_o` is high, `bit_vld_i`/`bit_i` and `byte_vld_i`/`byte_i` have no effect on the result. A serial bit offered in the cycle a byte is accepted is also ignored.
- R7: `crc_zero_o` is 1 exactly when `crc_o` is 8'h00. After the data bits, stepping in the eight bits of their CRC (least significant bit first) leaves the register at 8'h00.
- R8: From the zero seed, the byte 8'h01 gives 8'h5E. The ASCII bytes "123456789" (8'h31 to 8'h39, in that order) give 8'hA1.
- R9: Bits given one at a time on the serial port give the same CRC as the same bits packed into bytes on the byte port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release must be synchronised to the clock outside the unit |
| clr_i | input | 1 | Loads the zero seed |
| bit_vld_i | input | 1 | Serial bit strobe |
| bit_i | input | 1 | Serial data bit |
| byte_vld_i | input | 1 | Byte strobe, taken when not busy |
| byte_i | input | 8 | Byte to feed, least significant bit first |
| byte_busy_o | output | 1 | Byte feeder still shifting out bits 1 to 7 |
| crc_o | output | 8 | Current CRC register |
| crc_zero_o | output | 1 | CRC register equals zero |

## Verification
Two events can meet in one cycle. A clear can coincide with a step, and a serial bit can coincide with the byte feeder's own stepping. The bench first loads a non-zero CRC. It then raises the clear together with a serial bit of 1 and of 0, and expects 8'h8C and 8'h00 rather than a step on the old value. It also holds serial and byte strobes high, with values that would change the result, through the whole of a byte's feed. The final CRC must equal the value for that byte alone, and `byte_busy_o` must fall after seven cycles.

// File: rtl/owcrc_pkg.sv
package owcrc_pkg;
  localparam int unsigned CRC_W = 8;
  // x^8 + x^5 + x^4 + 1 in reflected (LSB-first) form
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;
  localparam logic [CRC_W-1:0] CRC_SEED = '0;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/owcrc_step.sv
module owcrc_step #(
  parameter int unsigned            W    = 8,
  parameter logic [W-1:0]           POLY = 8'h8C
) (
  input  logic [W-1:0] crc_cur,
  input  logic         din,
  output logic [W-1:0] crc_nxt
);
  logic fb;
  assign fb = din ^ crc_cur[0];

  // Right shift; the feedback bit is XORed wherever the reflected polynomial has a tap.
  for (genvar i = 0; i < W - 1; i++) begin : g_low
    if (POLY[i]) begin : g_tap
      assign crc_nxt[i] = crc_cur[i+1] ^ fb;
    end else begin : g_pass
      assign crc_nxt[i] = crc_cur[i+1];
    end
  end
  if (POLY[W-1]) begin : g_top_tap
    assign crc_nxt[W-1] = fb;
  end else begin : g_top_zero
    assign crc_nxt[W-1] = 1'b0;
  end
endmodule

// File: rtl/owcrc_byte_feeder.sv
module owcrc_byte_feeder #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              bit_vld_o,
  output logic              bit_o,
  output logic              busy_o
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              accept;
  logic              load_en;

  assign busy_o    = (cnt_q != '0);
  assign accept    = byte_vld_i && !busy_o;
  assign bit_vld_o = accept || busy_o;
  assign bit_o     = busy_o ? sh_q[0] : byte_i[0];
  assign load_en   = accept || busy_o;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (busy_o) begin
      sh_d  = sh_q >> 1;
      cnt_d = cnt_q - 1'b1;
    end else if (accept) begin
      sh_d  = byte_i >> 1;
      cnt_d = CNT_W'(DATA_W - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/owcrc_serial.sv
module owcrc_serial
  import owcrc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  input  logic bit_i,
  output crc_t crc_o
);
  crc_t crc_q, crc_d, base, stepped;
  logic en;

  assign base = clr_i ? CRC_SEED : crc_q;

  owcrc_step #(.W(CRC_W), .POLY(CRC_POLY_REFL)) u_step (
    .crc_cur (base),
    .din     (bit_i),
    .crc_nxt (stepped)
  );

  assign en = clr_i || step_i;

  always_comb begin
    crc_d = step_i ? stepped : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (en) begin
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/owcrc_unit.sv
module owcrc_unit
  import owcrc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              byte_busy_o,
  output logic [CRC_W-1:0]  crc_o,
  output logic              crc_zero_o
);
  logic fd_vld, fd_bit;
  logic step, step_bit;
  crc_t crc;

  owcrc_byte_feeder #(.DATA_W(DATA_W)) u_feed (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .bit_vld_o  (fd_vld),
    .bit_o      (fd_bit),
    .busy_o     (byte_busy_o)
  );

  // The byte feeder owns the generator whenever it steps; the serial strobe is dropped then.
  assign step     = fd_vld || bit_vld_i;
  assign step_bit = fd_vld ? fd_bit : bit_i;

  owcrc_serial u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .step_i (step),
    .bit_i  (step_bit),
    .crc_o  (crc)
  );

  assign crc_o      = crc;
  assign crc_zero_o = (crc == '0);
endmodule

// File: rtl/owcrc_unit_chk.sv
module owcrc_unit_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              bit_vld_i,
  input logic              bit_i,
  input logic              byte_vld_i,
  input logic [DATA_W-1:0] byte_i,
  input logic              byte_busy_o,
  input logic [7:0]        crc_o,
  input logic              crc_zero_o
);
  logic [15:0] run_q;
  logic        idle_in;

  assign idle_in = !bit_vld_i && !byte_vld_i && !byte_busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (byte_busy_o) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && idle_in) |=> (crc_o == 8'h00 && crc_zero_o)); // R3

  AST_CLEAR_WITH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && bit_vld_i && bit_i && !byte_vld_i && !byte_busy_o) |=> (crc_o == 8'h8C)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && idle_in) |=> $stable(crc_o)); // R4

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_busy_o) |-> $past(byte_vld_i)); // R5

  AST_BUSY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    byte_busy_o |-> (run_q < 16'(DATA_W - 1))); // R5

  AST_ZERO_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && idle_in) |=> !(|crc_o) == crc_zero_o); // R7
endmodule

bind owcrc_unit owcrc_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/owcrc_unit_tb.sv
module owcrc_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_i = 1'b0;
  logic       bit_vld_i = 1'b0;
  logic       bit_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       byte_busy_o;
  logic [7:0] crc_o;
  logic       crc_zero_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  owcrc_unit #(.DATA_W(8)) dut_i (.*);

  function automatic logic [7:0] m_bit(logic [7:0] c, logic b);
    logic f;
    f = b ^ c[0];
    c = c >> 1;
    if (f) c = c ^ 8'h8C;
    return c;
  endfunction

  function automatic logic [7:0] m_byte(logic [7:0] c, logic [7:0] v);
    for (int i = 0; i < 8; i++) c = m_bit(c, v[i]);
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v);
    @(negedge clk); byte_vld_i = 1'b1; byte_i = v;
    @(negedge clk); byte_vld_i = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); bit_vld_i = 1'b1; bit_i = b;
    @(negedge clk); bit_vld_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] exp, c_ser, c_byte, snap;
    logic [7:0] rom [7];
    logic [7:0] pad [8];
    int bad;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 crc in reset", crc_o, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 crc after reset", crc_o, 8'h00);
    chk("R1 zero flag after reset", crc_zero_o, 1'b1);
    chk("R1 busy after reset", byte_busy_o, 1'b0);

    // R8: fixed vectors
    send_byte(8'h01);
    chk("R8 byte 01", crc_o, 8'h5E);
    do_clear();
    for (int i = 0; i < 9; i++) send_byte(8'h31 + 8'(i));
    chk("R8 ascii 123456789", crc_o, 8'hA1);

    // R2/R7: exhaustive single byte sweep and zero residue
    bad = 0;
    for (int v = 0; v < 256; v++) begin
      do_clear();
      send_byte(8'(v));
      exp = m_byte(8'h00, 8'(v));
      if (crc_o !== exp || crc_zero_o !== (exp == 8'h00)) bad++;
      send_byte(exp);
      if (crc_o !== 8'h00 || crc_zero_o !== 1'b1) bad++;
    end
    chk("R2 R7 single byte sweep mismatches", bad, 0);

    // R2: serial single steps from a known value
    do_clear();
    send_bit(1'b1);
    chk("R2 one bit from zero", crc_o, 8'h8C);
    send_bit(1'b0);
    chk("R2 second bit zero", crc_o, m_bit(8'h8C, 1'b0));

    // R7: identity of 56 data bits plus check byte
    rom[0] = 8'h28;
    for (int i = 1; i < 7; i++) rom[i] = 8'(8'h17 * i + 8'h3B);
    do_clear();
    exp = 8'h00;
    for (int i = 0; i < 7; i++) begin
      send_byte(rom[i]);
      exp = m_byte(exp, rom[i]);
    end
    chk("R7 identity crc", crc_o, exp);
    send_byte(exp);
    chk("R7 identity residue zero", crc_o, 8'h00);
    chk("R7 identity zero flag", crc_zero_o, 1'b1);

    // R9: serial path equals byte path for a scratchpad image
    for (int i = 0; i < 8; i++) pad[i] = 8'(8'hA5 ^ (i * 8'h29));
    do_clear();
    for (int i = 0; i < 8; i++) send_byte(pad[i]);
    c_byte = crc_o;
    do_clear();
    for (int i = 0; i < 8; i++)
      for (int b = 0; b < 8; b++) send_bit(pad[i][b]);
    c_ser = crc_o;
    chk("R9 serial vs byte", c_ser, c_byte);
    exp = 8'h00;
    for (int i = 0; i < 8; i++) exp = m_byte(exp, pad[i]);
    chk("R9 scratchpad crc", c_byte, exp);

    // R4: hold with no activity
    snap = crc_o;
    repeat (5) @(negedge clk);
    chk("R4 hold idle", crc_o, snap);
    chk("R4 zero flag follows", crc_zero_o, (snap == 8'h00));

    // R3: clear collides with a step
    @(negedge clk); clr_i = 1'b1; bit_vld_i = 1'b1; bit_i = 1'b1;
    @(negedge clk); clr_i = 1'b0; bit_vld_i = 1'b0;
    chk("R3 clear plus bit 1", crc_o, 8'h8C);
    send_byte(8'h77);
    @(negedge clk); clr_i = 1'b1; bit_vld_i = 1'b1; bit_i = 1'b0;
    @(negedge clk); clr_i = 1'b0; bit_vld_i = 1'b0;
    chk("R3 clear plus bit 0", crc_o, 8'h00);
    send_byte(8'h55);
    do_clear();
    chk("R3 clear alone", crc_o, 8'h00);

    // R5/R6: busy window and ignored inputs
    @(negedge clk); byte_vld_i = 1'b1; byte_i = 8'hA5; bit_vld_i = 1'b1; bit_i = 1'b1;
    @(negedge clk); byte_i = 8'hFF;
    chk("R5 busy after accept", byte_busy_o, 1'b1);
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (byte_busy_o !== 1'b1) bad++;
    end
    chk("R5 busy through bits 1..7", bad, 0);
    @(negedge clk); byte_vld_i = 1'b0; bit_vld_i = 1'b0;
    chk("R5 busy drops after seven cycles", byte_busy_o, 1'b0);
    chk("R6 inputs ignored while busy", crc_o, m_byte(8'h00, 8'hA5));

    finish_run();
  end
endmodule